// File: doc/BRIEF.md
# Serial Comma Detector and Word Aligner

This block takes a recovered serial bit stream, one bit per clock when a bit-valid strobe is high, with the earliest bit first. It packs the bits into 20-bit words, each made of two 10-bit characters, and presents each finished word on a parallel output together with a one-cycle word-valid strobe. Bit 0 of every word is the earliest bit received.

When the detect enable is high, the block checks every bit position of the incoming stream for the 7-bit synchronization pattern. When it finds one, it moves the word boundary so that the pattern lands in bits 0 to 6 of the next word. That word is flagged with a comma-detect pulse. A pattern that sits anywhere else is treated as misaligned: deeper inside a character, in the second character, or across the two characters. Realigning drops the partially built word. The comma and everything after it come out on the new boundary. When the enable is low, the current boundary is kept whatever the data.

Top module: `cdwa_aligner`

## Requirements
- R1: While reset is asserted, `word_o` is all zeros and `word_vld_o` and `com_det_o` are low.
- R2: Only cycles with `bit_vld_i` high advance the stream. Each group of 20 accepted bits is presented as one word, with the earliest bit in bit 0. Cycles with `bit_vld_i` low change nothing.
- R3: With `det_en_i` low, the word boundary never moves, the pattern is ignored at every offset, and `com_det_o` stays low.
- R4: The synchronization pattern is the 7 bits 0,0,1,1,1,1,1 in order of arrival. In a word this means bit k+0 = 0, bit k+1 = 0 and bits k+2 to k+6 = 1. With `det_en_i` high, it is recognised starting at any bit position.
- R5: If the pattern starts at stream index o (counted from 0 after reset), exactly floor((o+7)/20) words are emitted before the word that starts at index o. That word and all later words follow each other without gaps in the stream, each 20 bits long.
- R6: `com_det_o` is high for one cycle, together with `word_vld_o`, on the word that carries the pattern in bits 0 to 6. This happens for every detected pattern, including one that was already aligned.
- R7: A pattern found in the second character, or across the character boundary, counts as misaligned and moves the boundary. A complete word that holds such a pattern is emitted without `com_det_o`.
- R8: `word_vld_o` is a single-cycle pulse that follows an accepted bit. The partial word cut short by a realignment gets no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_i | input | 1 | Serial data bit |
| bit_vld_i | input | 1 | Qualifies `bit_i` in this cycle |
| det_en_i | input | 1 | Enables pattern search and realignment |
| word_o | output | 20 | Assembled word, bit 0 earliest |
| word_vld_o | output | 1 | One-cycle pulse when `word_o` is updated |
| com_det_o | output | 1 | Marks the word that starts with the pattern |

## Verification
The hardest cases to reach from the ports are the phases where the pattern crosses the old word boundary or the character boundary. In those cases a complete old word is still emitted at the moment the boundary moves. The stimulus sweeps the pattern start across 40 consecutive stream offsets, both with an unbroken strobe and with idle cycles mixed in. For each offset the bench works out arithmetically how many words come first and what each word holds. Separate streams place a second pattern in the second character, repeat an already aligned pattern, and turn the enable off just before a misaligned pattern.

// File: rtl/cdwa_pkg.sv
package cdwa_pkg;
  localparam int unsigned CHAR_BITS  = 10;
  localparam int unsigned CHAR_COUNT = 2;
  localparam int unsigned PAT_BITS   = 7;
  // arrival order: bit 0 first -> 0,0,1,1,1,1,1
  localparam logic [PAT_BITS-1:0] SYNC_PAT = 7'b1111100;
endpackage

// File: rtl/cdwa_rst_sync.sv
module cdwa_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/cdwa_shifter.sv
module cdwa_shifter #(
  parameter int unsigned WIDTH = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_en_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] win_nxt_o
);
  logic [WIDTH-1:0] win_q;
  logic [WIDTH-1:0] win_d;

  // newest bit enters at the top; the oldest sits at index 0
  for (genvar g = 0; g < WIDTH; g++) begin : g_stage
    if (g == WIDTH - 1) begin : g_head
      assign win_nxt_o[g] = bit_i;
    end else begin : g_body
      assign win_nxt_o[g] = win_q[g+1];
    end
  end

  always_comb begin
    win_d = shift_en_i ? win_nxt_o : win_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q <= '0;
    else         win_q <= win_d;
  end
endmodule

// File: rtl/cdwa_matcher.sv
module cdwa_matcher #(
  parameter int unsigned                WIDTH = 20,
  parameter int unsigned                PW    = 7,
  parameter logic [PW-1:0]              PAT   = 7'b1111100
) (
  input  logic [WIDTH-1:0] win_i,
  input  logic             en_i,
  output logic             hit_o
);
  localparam int unsigned BASE = WIDTH - PW;
  logic [PW-1:0] eq;

  // compare the newest PW bits; the pattern's first bit is the oldest of them
  for (genvar g = 0; g < PW; g++) begin : g_cmp
    assign eq[g] = ~(win_i[BASE+g] ^ PAT[g]);
  end

  assign hit_o = en_i & (&eq);
endmodule

// File: rtl/cdwa_ctrl.sv
module cdwa_ctrl #(
  parameter int unsigned WORD_W = 20,
  parameter int unsigned PW     = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic det_en_i,
  input  logic hit_i,
  output logic emit_o,
  output logic cd_emit_o
);
  localparam int unsigned FW = $clog2(WORD_W + 1);
  localparam logic [FW-1:0] LAST = FW'(WORD_W);
  localparam logic [FW-1:0] ALN  = FW'(PW);

  logic [FW-1:0] fill_q, fill_d, fill_inc;
  logic          flag_q, flag_d;
  logic          full, hit;

  always_comb begin
    fill_inc  = fill_q + 1'b1;
    full      = (fill_inc == LAST);
    hit       = bit_vld_i & hit_i;
    emit_o    = bit_vld_i & full;
    cd_emit_o = emit_o & flag_q;
    fill_d    = fill_q;
    flag_d    = flag_q;
    if (bit_vld_i) begin
      if (hit)       fill_d = ALN;
      else if (full) fill_d = '0;
      else           fill_d = fill_inc;
      if (hit)         flag_d = 1'b1;
      else if (emit_o) flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      flag_q <= 1'b0;
    end else begin
      fill_q <= fill_d;
      flag_q <= flag_d;
    end
  end

  // R2
  fill_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q < LAST);

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> $stable(fill_q) && $stable(flag_q));

  // R3
  freeze_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && !det_en_i) |=>
      fill_q == ((($past(fill_q) + 1'b1) == LAST) ? '0 : ($past(fill_q) + 1'b1)));
endmodule

// File: rtl/cdwa_aligner.sv
module cdwa_aligner
  import cdwa_pkg::*;
#(
  parameter int unsigned CW  = CHAR_BITS,
  parameter int unsigned NCH = CHAR_COUNT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_i,
  input  logic                bit_vld_i,
  input  logic                det_en_i,
  output logic [CW*NCH-1:0]   word_o,
  output logic                word_vld_o,
  output logic                com_det_o
);
  localparam int unsigned WORD_W = CW * NCH;

  logic              rst_n;
  logic [WORD_W-1:0] win_nxt;
  logic              hit, emit, cd_emit;
  logic [WORD_W-1:0] word_q, word_d;
  logic              vld_q, vld_d, cd_q, cd_d;

  cdwa_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  cdwa_shifter #(.WIDTH(WORD_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .shift_en_i (bit_vld_i),
    .bit_i      (bit_i),
    .win_nxt_o  (win_nxt)
  );

  cdwa_matcher #(.WIDTH(WORD_W), .PW(PAT_BITS), .PAT(SYNC_PAT)) u_match (
    .win_i (win_nxt),
    .en_i  (det_en_i),
    .hit_o (hit)
  );

  cdwa_ctrl #(.WORD_W(WORD_W), .PW(PAT_BITS)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .bit_vld_i (bit_vld_i),
    .det_en_i  (det_en_i),
    .hit_i     (hit),
    .emit_o    (emit),
    .cd_emit_o (cd_emit)
  );

  always_comb begin
    word_d = emit ? win_nxt : word_q;
    vld_d  = emit;
    cd_d   = cd_emit;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
      cd_q   <= 1'b0;
    end else begin
      word_q <= word_d;
      vld_q  <= vld_d;
      cd_q   <= cd_d;
    end
  end

  assign word_o     = word_q;
  assign word_vld_o = vld_q;
  assign com_det_o  = cd_q;

  // R6
  comdet_with_word_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    com_det_o |-> word_vld_o);

  // R6
  comdet_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    com_det_o |-> (word_o[PAT_BITS-1:0] == SYNC_PAT));

  // R8
  vld_needs_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    word_vld_o |-> $past(bit_vld_i));

  // R8
  vld_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    word_vld_o |=> !word_vld_o);
endmodule

// File: tb/tb_cdwa_aligner.sv
module tb_cdwa_aligner;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_i = 1'b0;
  logic        bit_vld_i = 1'b0;
  logic        det_en_i = 1'b0;
  logic [19:0] word_o;
  logic        word_vld_o;
  logic        com_det_o;

  cdwa_aligner dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_i      (bit_i),
    .bit_vld_i  (bit_vld_i),
    .det_en_i   (det_en_i),
    .word_o     (word_o),
    .word_vld_o (word_vld_o),
    .com_det_o  (com_det_o)
  );

  always #2.5 clk_i = ~clk_i;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic        sbit [0:511];
  logic        sen  [0:511];
  int          slen;
  logic        altb;
  logic        cur_en;

  logic [19:0] warr [0:63];
  logic        carr [0:63];
  int          nw;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk_i) begin
    if (word_vld_o && nw < 64) begin
      warr[nw] = word_o;
      carr[nw] = com_det_o;
      nw++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    slen = 0;
    altb = 1'b0;
  endtask

  task automatic put_alt(input int n);
    for (int i = 0; i < n; i++) begin
      sbit[slen] = altb;
      sen[slen]  = cur_en;
      altb = ~altb;
      slen++;
    end
  endtask

  task automatic put_pat();
    for (int i = 0; i < 7; i++) begin
      sbit[slen] = (i >= 2);
      sen[slen]  = cur_en;
      slen++;
    end
  endtask

  function automatic logic [19:0] sw(input int s);
    logic [19:0] w;
    for (int k = 0; k < 20; k++) w[k] = sbit[s+k];
    return w;
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    bit_vld_i = 1'b0;
    det_en_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    nw = 0;
  endtask

  task automatic run(input bit gap);
    do_reset();
    for (int i = 0; i < slen; i++) begin
      if (gap && (i % 3 == 1)) begin
        @(negedge clk_i);
        bit_vld_i = 1'b0;
        bit_i = ~bit_i;
        det_en_i = ~det_en_i;
      end
      @(negedge clk_i);
      bit_i = sbit[i];
      det_en_i = sen[i];
      bit_vld_i = 1'b1;
    end
    @(negedge clk_i);
    bit_vld_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  function automatic int cd_sum();
    int s = 0;
    for (int i = 0; i < nw; i++) s += carr[i];
    return s;
  endfunction

  initial begin
    nw = 0;
    // R1: reset state
    @(negedge clk_i);
    chk(word_o == 20'h0, "R1 word in reset", 32'(word_o), 0);
    chk(!word_vld_o, "R1 vld in reset", 32'(word_vld_o), 0);
    chk(!com_det_o, "R1 comdet in reset", 32'(com_det_o), 0);

    // R3 and R2: disabled, pattern at offset 3 ignored
    clr(); cur_en = 1'b0;
    put_alt(3); put_pat(); put_alt(50);
    run(1'b0);
    chk(nw == 3, "R3 word count disabled", 32'(nw), 3);
    for (int i = 0; i < 3; i++) begin
      chk(warr[i] == sw(20*i), "R2 word order disabled", 32'(warr[i]), 32'(sw(20*i)));
      chk(!carr[i], "R3 no comdet disabled", 32'(carr[i]), 0);
    end

    // R4 R5 R6 R7 R8: sweep pattern start over 40 offsets, with and without idles
    for (int g = 0; g < 2; g++) begin
      for (int o = 0; o < 40; o++) begin
        int pre;
        clr(); cur_en = 1'b1;
        put_alt(o); put_pat(); put_alt(53);
        run(g[0]);
        pre = (o + 7) / 20;
        chk(nw == pre + 3, "R5 word count", 32'(nw), 32'(pre + 3));
        if (nw == pre + 3) begin
          chk(warr[pre] == sw(o), "R5 aligned pattern word", 32'(warr[pre]), 32'(sw(o)));
          chk(warr[pre][6:0] == 7'b1111100, "R4 pattern in bits 0-6", 32'(warr[pre][6:0]), 32'h7c);
          chk(carr[pre], "R6 comdet on pattern word", 32'(carr[pre]), 1);
          chk(warr[pre+1] == sw(o+20), "R5 next word", 32'(warr[pre+1]), 32'(sw(o+20)));
          chk(warr[pre+2] == sw(o+40), "R2 third word", 32'(warr[pre+2]), 32'(sw(o+40)));
          if (pre > 0)
            chk(warr[0] == sw(0) && !carr[0], "R7 old word kept unflagged",
                32'(warr[0]), 32'(sw(0)));
        end
        chk(cd_sum() == 1, "R6 single comdet", 32'(cd_sum()), 1);
      end
    end

    // R7: second pattern in the second character moves the boundary
    clr(); cur_en = 1'b1;
    put_pat(); put_alt(3); put_pat(); put_alt(53);
    run(1'b0);
    chk(nw == 3, "R7 count second-char pattern", 32'(nw), 3);
    chk(warr[0] == sw(10), "R7 realigned to second char", 32'(warr[0]), 32'(sw(10)));
    chk(carr[0], "R7 comdet after second-char", 32'(carr[0]), 1);
    chk(cd_sum() == 1, "R8 dropped partial word unflagged", 32'(cd_sum()), 1);

    // R6: two aligned patterns in a row both flagged
    clr(); cur_en = 1'b1;
    put_alt(5); put_pat(); put_alt(13); put_pat(); put_alt(33);
    run(1'b1);
    chk(nw == 3, "R6 count repeat pattern", 32'(nw), 3);
    chk(carr[0] && carr[1] && !carr[2], "R6 comdet on each pattern",
        {29'd0, carr[0], carr[1], carr[2]}, 32'h6);
    chk(warr[1] == sw(25), "R6 second pattern word", 32'(warr[1]), 32'(sw(25)));

    // R3: enable dropped before a misaligned second pattern keeps the boundary
    clr(); cur_en = 1'b1;
    put_alt(3); put_pat(); cur_en = 1'b0;
    put_alt(17); put_pat(); put_alt(49);
    run(1'b0);
    chk(nw == 4, "R3 count freeze", 32'(nw), 4);
    for (int i = 0; i < 4; i++)
      chk(warr[i] == sw(3 + 20*i), "R3 boundary frozen", 32'(warr[i]), 32'(sw(3 + 20*i)));
    chk(carr[0] && cd_sum() == 1, "R3 no comdet when disabled", 32'(cd_sum()), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule